// File: doc/BRIEF.md
# Sampled Event Spy Buffer

The block taps a stream of 32-bit event words, marked by start and end strobes, and copies a chosen subset of whole events into a monitoring FIFO that holds 4096 words. A host drains that FIFO one word per read strobe and watches its fill level and flags. Nothing the block does affects the stream it taps.

A 2-bit policy input chooses which events are taken. One policy takes an event only when the buffer is empty. One takes every event. Two take only every 4th or every 8th event seen on the stream. Words of an event in progress go into the storage array at once but become visible only when the end word arrives. An event that runs out of space is discarded as a whole. A clear strobe empties the buffer and aborts any capture in progress.

Top module: `evt_spy_buf`

## Requirements
- R1: With cfg_mode_i = 0, an event is stored only if the buffer holds zero committed words in the cycle of its start word.
- R2: With cfg_mode_i = 1, every event that fits in the free space is stored.
- R3: With cfg_mode_i = 2 or 3, an event is stored when its index is a multiple of 4 or 8, provided it fits. The index counts every start word seen since the last mode change, stored or not, and the first event has index 0.
- R4: Any change of cfg_mode_i restarts the event index at 0.
- R5: An event whose words do not all fit is dropped entirely. level_o rises only in the cycle after an end word, and then by the full length of the event.
- R6: host_rd_i on a non-empty buffer returns the oldest word on host_rdata_o in the next cycle and lowers level_o by one. Words leave in the order they were written.
- R7: host_rd_i on an empty buffer returns 0x00000000 in the next cycle and changes no state.
- R8: After reset, or in the cycle after spy_clr_i, the buffer is empty: level_o = 0, host_rdata_o = 0, only empty_o and aempty_o are high, and any partly received event is discarded.
- R9: empty_o is high at 0 words, aempty_o at 4 words or fewer, half_o at DEPTH/2 words or more, afull_o at DEPTH-4 words or more, and full_o at DEPTH words.
- R10: level_o gives the number of committed, unread words, zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Sampling policy: 0 store when empty, 1 all, 2 every 4th, 3 every 8th |
| spy_clr_i | input | 1 | Clear strobe: empties the buffer and aborts capture |
| evt_valid_i | input | 1 | Stream word valid |
| evt_sop_i | input | 1 | First word of an event |
| evt_eop_i | input | 1 | Last word of an event |
| evt_data_i | input | DATA_W | Stream word |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | DATA_W | Read data, valid the cycle after the strobe |
| level_o | output | 16 | Committed word count |
| empty_o | output | 1 | No words |
| aempty_o | output | 1 | 4 words or fewer |
| half_o | output | 1 | At least half full |
| afull_o | output | 1 | Within 4 words of full |
| full_o | output | 1 | Full |

## Verification
The bench builds the block with DEPTH_LOG2 = 4, so the buffer holds 16 words, half_o sets at 8 words and afull_o at 12. At that size a few events reach each flag threshold. A sweep over all four policies and event lengths 1 to 6 soon fills the buffer, so events are dropped at the boundary. The every-4th and every-8th patterns also come round several times within each policy.

// File: rtl/evt_spy_pkg.sv
package evt_spy_pkg;
  typedef enum logic [1:0] {
    SPY_IF_EMPTY = 2'd0,
    SPY_ALL      = 2'd1,
    SPY_EVERY4   = 2'd2,
    SPY_EVERY8   = 2'd3
  } spy_mode_e;

  localparam int unsigned LEVEL_W = 16;
endpackage

// File: rtl/spy_sampler.sv
module spy_sampler
  import evt_spy_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  spy_mode_e mode_i,
  input  logic      sop_stb_i,
  input  logic      buf_empty_i,
  output logic      take_o
);
  logic [IDX_W-1:0] idx_q, idx_eff;
  spy_mode_e        mode_q;
  logic             mode_chg;

  assign mode_chg = (mode_i != mode_q);
  assign idx_eff  = mode_chg ? '0 : idx_q;

  always_comb begin
    unique case (mode_i)
      SPY_IF_EMPTY: take_o = buf_empty_i;
      SPY_ALL:      take_o = 1'b1;
      SPY_EVERY4:   take_o = (idx_eff[1:0] == 2'd0);
      default:      take_o = (idx_eff[2:0] == 3'd0);
    endcase
  end

  // index counts every event seen, stored or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mode_q <= SPY_IF_EMPTY;
    end else begin
      mode_q <= mode_i;
      if (sop_stb_i)     idx_q <= idx_eff + 1'b1;
      else if (mode_chg) idx_q <= '0;
    end
  end
endmodule

// File: rtl/spy_store.sv
module spy_store #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH_LOG2 = 12,
  localparam int unsigned PTR_W     = DEPTH_LOG2 + 1,
  localparam int unsigned DEPTH     = 1 << DEPTH_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [PTR_W-1:0]  rd_ptr_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, spec_q, rd_q, base, occ;
  logic              cap_q, want, room, accept, has_data;

  assign base     = sop_i ? wr_q : spec_q;
  assign occ      = base - rd_q;
  assign room     = (occ != PTR_W'(DEPTH));
  assign want     = valid_i && (sop_i ? take_i : cap_q);
  assign accept   = want && room && !clr_i;
  assign has_data = (rd_q != wr_q);

  always_ff @(posedge clk_i) begin
    if (accept) mem[base[DEPTH_LOG2-1:0]] <= data_i;
  end

  // speculative pointer runs ahead; committed pointer moves on end word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      spec_q <= '0;
      cap_q  <= 1'b0;
    end else if (clr_i) begin
      wr_q   <= '0;
      spec_q <= '0;
      cap_q  <= 1'b0;
    end else if (valid_i && (sop_i || cap_q)) begin
      if (want && room) begin
        spec_q <= base + 1'b1;
        cap_q  <= !eop_i;
        if (eop_i) wr_q <= base + 1'b1;
      end else begin
        spec_q <= wr_q;
        cap_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      rdata_o <= '0;
    end else if (clr_i) begin
      rd_q    <= '0;
      rdata_o <= '0;
    end else if (rd_i) begin
      if (has_data) begin
        rdata_o <= mem[rd_q[DEPTH_LOG2-1:0]];
        rd_q    <= rd_q + 1'b1;
      end else begin
        rdata_o <= '0;
      end
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
endmodule

// File: rtl/spy_flags.sv
module spy_flags
  import evt_spy_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2   = 12,
  parameter int unsigned AEMPTY_LVL   = 4,
  parameter int unsigned AFULL_MARGIN = 4,
  localparam int unsigned PTR_W       = DEPTH_LOG2 + 1,
  localparam int unsigned DEPTH       = 1 << DEPTH_LOG2
) (
  input  logic [PTR_W-1:0]   wr_ptr_i,
  input  logic [PTR_W-1:0]   rd_ptr_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic               empty_o,
  output logic               aempty_o,
  output logic               half_o,
  output logic               afull_o,
  output logic               full_o
);
  logic [PTR_W-1:0] lvl;

  assign lvl      = wr_ptr_i - rd_ptr_i;
  assign level_o  = LEVEL_W'(lvl);
  assign empty_o  = (lvl == '0);
  assign aempty_o = (lvl <= PTR_W'(AEMPTY_LVL));
  assign half_o   = (lvl >= PTR_W'(DEPTH / 2));
  assign afull_o  = (lvl >= PTR_W'(DEPTH - AFULL_MARGIN));
  assign full_o   = (lvl == PTR_W'(DEPTH));
endmodule

// File: rtl/evt_spy_buf.sv
module evt_spy_buf
  import evt_spy_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned DEPTH_LOG2   = 12,
  parameter int unsigned AEMPTY_LVL   = 4,
  parameter int unsigned AFULL_MARGIN = 4,
  localparam int unsigned PTR_W       = DEPTH_LOG2 + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cfg_mode_i,
  input  logic               spy_clr_i,
  input  logic               evt_valid_i,
  input  logic               evt_sop_i,
  input  logic               evt_eop_i,
  input  logic [DATA_W-1:0]  evt_data_i,
  input  logic               host_rd_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic               empty_o,
  output logic               aempty_o,
  output logic               half_o,
  output logic               afull_o,
  output logic               full_o
);
  logic             take;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  spy_sampler #(.IDX_W(3)) u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (spy_mode_e'(cfg_mode_i)),
    .sop_stb_i   (evt_valid_i && evt_sop_i),
    .buf_empty_i (empty_o),
    .take_o      (take)
  );

  spy_store #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (spy_clr_i),
    .valid_i  (evt_valid_i),
    .sop_i    (evt_sop_i),
    .eop_i    (evt_eop_i),
    .data_i   (evt_data_i),
    .take_i   (take),
    .rd_i     (host_rd_i),
    .rdata_o  (host_rdata_o),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr)
  );

  spy_flags #(
    .DEPTH_LOG2(DEPTH_LOG2), .AEMPTY_LVL(AEMPTY_LVL), .AFULL_MARGIN(AFULL_MARGIN)
  ) u_flags (
    .wr_ptr_i (wr_ptr),
    .rd_ptr_i (rd_ptr),
    .level_o  (level_o),
    .empty_o  (empty_o),
    .aempty_o (aempty_o),
    .half_o   (half_o),
    .afull_o  (afull_o),
    .full_o   (full_o)
  );
endmodule

// File: rtl/evt_spy_buf_chk.sv
module evt_spy_buf_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH_LOG2 = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spy_clr_i,
  input logic              evt_valid_i,
  input logic              evt_eop_i,
  input logic              host_rd_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic [15:0]       level_o,
  input logic              empty_o,
  input logic              aempty_o,
  input logic              half_o,
  input logic              afull_o,
  input logic              full_o
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  assert_clr_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spy_clr_i |=> (empty_o && level_o == 16'd0 && host_rdata_o == '0));

  assert_empty_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && empty_o && !spy_clr_i && !(evt_valid_i && evt_eop_i))
      |=> (host_rdata_o == '0 && level_o == 16'd0));

  assert_grow_on_eop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_valid_i && evt_eop_i) |=> (level_o <= $past(level_o)));

  assert_read_pops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !empty_o && !spy_clr_i && !(evt_valid_i && evt_eop_i))
      |=> (level_o == $past(level_o) - 16'd1));

  assert_level_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= 16'(DEPTH));

  assert_flag_nest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (afull_o && half_o && !empty_o));

  assert_empty_nest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (aempty_o && !half_o));
endmodule

bind evt_spy_buf evt_spy_buf_chk #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .spy_clr_i    (spy_clr_i),
  .evt_valid_i  (evt_valid_i),
  .evt_eop_i    (evt_eop_i),
  .host_rd_i    (host_rd_i),
  .host_rdata_o (host_rdata_o),
  .level_o      (level_o),
  .empty_o      (empty_o),
  .aempty_o     (aempty_o),
  .half_o       (half_o),
  .afull_o      (afull_o),
  .full_o       (full_o)
);

// File: tb/evt_spy_buf_bench.sv
module evt_spy_buf_bench;
  localparam int DEPTH_LOG2 = 4;
  localparam int DEPTH      = 1 << DEPTH_LOG2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_mode_i = 2'd0;
  logic        spy_clr_i = 1'b0;
  logic        evt_valid_i = 1'b0, evt_sop_i = 1'b0, evt_eop_i = 1'b0;
  logic [31:0] evt_data_i = '0;
  logic        host_rd_i = 1'b0;
  logic [31:0] host_rdata_o;
  logic [15:0] level_o;
  logic        empty_o, aempty_o, half_o, afull_o, full_o;

  always #4 clk_i = ~clk_i;

  evt_spy_buf #(.DATA_W(32), .DEPTH_LOG2(DEPTH_LOG2)) u_evt_spy_buf (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] mq[$];
  int ev_cnt = 0;
  int cur_mode = 0;
  int tag = 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    int s = mq.size();
    logic [4:0] ef, af;
    ef = {s == 0, s <= 4, s >= DEPTH / 2, s >= DEPTH - 4, s == DEPTH};
    af = {empty_o, aempty_o, half_o, afull_o, full_o};
    chk(level_o == 16'(s), {req, " level R10"}, 32'(level_o), 32'(s));
    chk(af == ef, {req, " flags R9"}, 32'(af), 32'(ef));
  endtask

  task automatic set_mode(input int m);
    @(negedge clk_i);
    cfg_mode_i = 2'(m);
    if (m != cur_mode) ev_cnt = 0;
    cur_mode = m;
    @(negedge clk_i);
  endtask

  task automatic send_event(input int len);
    bit take;
    int n;
    n = (cur_mode == 2) ? 4 : (cur_mode == 3) ? 8 : 1;
    if (cur_mode == 0) take = (mq.size() == 0);
    else take = ((ev_cnt % n) == 0);
    ev_cnt++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      evt_valid_i = 1'b1;
      evt_sop_i   = (i == 0);
      evt_eop_i   = (i == len - 1);
      evt_data_i  = {16'(tag), 16'(i)};
    end
    if (take && (mq.size() + len <= DEPTH))
      for (int i = 0; i < len; i++) mq.push_back({16'(tag), 16'(i)});
    tag++;
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_sop_i = 1'b0; evt_eop_i = 1'b0;
  endtask

  task automatic host_read(output logic [31:0] d);
    @(negedge clk_i);
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
    d = host_rdata_o;
  endtask

  task automatic drain(input string req);
    logic [31:0] d, e;
    while (mq.size() > 0) begin
      e = mq.pop_front();
      host_read(d);
      chk(d == e, {req, " read order R6"}, d, e);
    end
    chk_state({req, " drained"});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_state("reset R8");
    chk(host_rdata_o == 32'd0, "reset rdata R8", host_rdata_o, 32'd0);

    // empty read returns zero, no state change
    host_read(d);
    chk(d == 32'd0, "empty read R7", d, 32'd0);
    chk_state("empty read R7");

    // mode 1 fill to boundary, overflow skip
    set_mode(1);
    send_event(3); send_event(2); send_event(5);
    chk_state("fill R2");
    send_event(4);
    chk_state("afull R9");
    send_event(3);
    chk_state("overflow drop R5");
    send_event(2);
    chk_state("full R9");
    drain("mode1");
    host_read(d);
    chk(d == 32'd0, "read after drain R7", d, 32'd0);
    chk_state("read after drain R7");
    send_event(DEPTH + 1);
    chk_state("oversize drop R5");

    // partial event invisible until end word
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      evt_valid_i = 1'b1; evt_sop_i = (i == 0); evt_eop_i = 1'b0;
      evt_data_i = {16'(tag), 16'(i)};
    end
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_sop_i = 1'b0;
    chk(level_o == 16'd0, "partial not visible R5", 32'(level_o), 32'd0);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_eop_i = 1'b1; evt_data_i = {16'(tag), 16'd3};
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_eop_i = 1'b0;
    for (int i = 0; i < 4; i++) mq.push_back({16'(tag), 16'(i)});
    tag++; ev_cnt++;
    chk_state("commit on end R5");

    // clear while full-ish, and clear mid-event
    send_event(6);
    @(negedge clk_i);
    spy_clr_i = 1'b1;
    @(negedge clk_i);
    spy_clr_i = 1'b0;
    mq.delete();
    chk_state("clear R8");
    chk(host_rdata_o == 32'd0, "clear rdata R8", host_rdata_o, 32'd0);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_sop_i = 1'b1; evt_data_i = 32'hAAAA_0000;
    @(negedge clk_i);
    evt_sop_i = 1'b0; evt_valid_i = 1'b0; spy_clr_i = 1'b1;
    @(negedge clk_i);
    spy_clr_i = 1'b0; evt_valid_i = 1'b1; evt_eop_i = 1'b1; evt_data_i = 32'hAAAA_0001;
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_eop_i = 1'b0;
    ev_cnt++;
    chk_state("clear aborts capture R8");

    // mode change restarts index
    set_mode(2);
    send_event(1); send_event(1);
    chk_state("every4 start R3");
    set_mode(3);
    set_mode(2);
    send_event(1);
    chk_state("index restart R4");
    drain("R4");

    // sweep over policies and lengths
    for (int m = 0; m < 4; m++) begin
      for (int len = 1; len <= 6; len++) begin
        string rq;
        rq = (m == 0) ? "R1" : (m == 1) ? "R2" : "R3";
        set_mode(m);
        for (int k = 0; k < 12; k++) begin
          send_event(len);
          chk_state(rq);
        end
        drain(rq);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule